// File: doc/BRIEF.md
# Modem Status Delta Detector

This block watches four active-low handshake inputs from a modem or peer device: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents an 8-bit status value. The upper nibble holds the asserted (inverted) level of each line, and the lower nibble holds sticky change flags. The change flags stay set until the host reads the status. Any set flag raises an interrupt request. The interrupt enable lives elsewhere.

Each pin passes through a synchronizer before edge detection. After reset, a short settle window loads the previous-level registers from the synchronized pins, so no false change is reported. In loopback mode the four levels come from modem-control register bits instead of the pins.

The block also gates the transmitter for hardware flow control. When flow control is on and clear-to-send is not asserted, the transmit-allowed output drops at the end of the character in flight. It rises again once clear-to-send is asserted or flow control is turned off.

Top module: `modem_status_monitor`

## Requirements
- R1: status_o bits 0, 1 and 3 set when the asserted level of clear-to-send, data-set-ready or carrier-detect (status bits 4, 5, 7) changes in either direction. The flag appears one cycle after the new level.
- R2: status_o bit 2 sets only when the ring pin ri_n_i goes from 0 to 1, which is when status bit 6 falls. A ring pin falling from 1 to 0 leaves bit 2 clear.
- R3: A cycle with status_rd_i high clears all four change bits at the next clock edge. Without a read, a set change bit stays set.
- R4: If a change is detected in the same cycle as a read, that change bit ends up set, while the other bits are still cleared.
- R5: irq_o is high exactly when at least one of status_o bits 0..3 is set.
- R6: Outside loopback, status_o bits 4, 5, 6 and 7 equal the inverted cts_n_i, dsr_n_i, ri_n_i and dcd_n_i pins. Each shows two clock edges after the pin changes (SYNC_STAGES = 2).
- R7: With loop_en_i high, status_o bits 4..7 follow lb_rts_i, lb_dtr_i, lb_out1_i and lb_out2_i directly. Changes on these set the change bits by the rules of R1 and R2, one edge later.
- R8: With flow_en_i high and status bit 4 at 0, a char_done_i pulse makes tx_allow_o low from the next cycle. Without a char_done_i pulse, tx_allow_o stays high even when bit 4 is 0.
- R9: While tx_allow_o is low, it returns high one edge after status bit 4 is 1 or flow_en_i is 0.
- R10: After reset, the change bits are 0 and irq_o is low, even when pins are held asserted through reset.
- R11: With flow_en_i low, char_done_i has no effect on tx_allow_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_i | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n_i | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n_i | input | 1 | Carrier-detect pin, active low, asynchronous |
| status_rd_i | input | 1 | Host read strobe of the status value |
| loop_en_i | input | 1 | Loopback mode select |
| lb_rts_i | input | 1 | Control bit looped onto the clear-to-send level |
| lb_dtr_i | input | 1 | Control bit looped onto the data-set-ready level |
| lb_out1_i | input | 1 | Control bit looped onto the ring level |
| lb_out2_i | input | 1 | Control bit looped onto the carrier-detect level |
| flow_en_i | input | 1 | Hardware flow control enable |
| char_done_i | input | 1 | Pulse from the transmitter at the end of a character |
| status_o | output | 8 | {dcd, ri, dsr, cts levels, dcd/ri/dsr/cts change flags} |
| irq_o | output | 1 | Modem-status interrupt request |
| tx_allow_o | output | 1 | Transmitter may start a new character |

## Verification
A pin change needs two edges to reach the level bits. It needs a third edge to reach the change flags and irq_o. Loopback bits reach the levels at once and the change flags one edge later. A read clears the flags one edge later. tx_allow_o moves one edge after the char_done_i pulse, or after the cts level or flow_en_i. The bench drives on falling edges and counts rising edges to each result. It samples exactly there, and also one cycle earlier where a result must not have appeared yet.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int LINES   = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  typedef logic [LINES-1:0] line_vec_t;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
  parameter int   WIDTH     = 4,
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {STAGES{RESET_VAL}};
      else if (STAGES == 1) pipe_q <= d_i[b];
      else pipe_q <= {pipe_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/msd_delta.sv
module msd_delta
  import msd_pkg::*;
#(
  parameter int SETTLE = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  line_vec_t lvl_i,
  input  logic      clr_i,
  output line_vec_t delta_o
);
  localparam int CW = $clog2(SETTLE + 1);

  line_vec_t       prev_q, delta_q, det;
  logic [CW-1:0]   cnt_q;
  logic            settled;

  assign settled = (cnt_q == CW'(SETTLE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!settled) cnt_q <= cnt_q + 1'b1;
  end

  // ring flags only the trailing edge of its asserted level
  for (genvar i = 0; i < LINES; i++) begin : g_det
    if (i == IDX_RI) begin : g_trail
      assign det[i] = settled & prev_q[i] & ~lvl_i[i];
    end else begin : g_any
      assign det[i] = settled & (prev_q[i] ^ lvl_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      delta_q <= '0;
    end else begin
      prev_q  <= lvl_i;
      delta_q <= (delta_q & ~{LINES{clr_i}}) | det;  // edge beats read
    end
  end

  assign delta_o = delta_q;
endmodule

// File: rtl/msd_flow.sv
module msd_flow (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flow_en_i,
  input  logic cts_act_i,
  input  logic char_done_i,
  output logic tx_allow_o
);
  logic halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) halt_q <= 1'b0;
    else if (!flow_en_i || cts_act_i) halt_q <= 1'b0;
    else if (char_done_i) halt_q <= 1'b1;
  end

  assign tx_allow_o = ~halt_q;
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
  import msd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cts_n_i,
  input  logic       dsr_n_i,
  input  logic       ri_n_i,
  input  logic       dcd_n_i,
  input  logic       status_rd_i,
  input  logic       loop_en_i,
  input  logic       lb_rts_i,
  input  logic       lb_dtr_i,
  input  logic       lb_out1_i,
  input  logic       lb_out2_i,
  input  logic       flow_en_i,
  input  logic       char_done_i,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       tx_allow_o
);
  localparam int SETTLE = SYNC_STAGES + 1;

  line_vec_t pin_n, pin_sync_n, lb_lvl, lvl, delta;

  always_comb begin
    pin_n          = '0;
    pin_n[IDX_CTS] = cts_n_i;
    pin_n[IDX_DSR] = dsr_n_i;
    pin_n[IDX_RI]  = ri_n_i;
    pin_n[IDX_DCD] = dcd_n_i;
    lb_lvl          = '0;
    lb_lvl[IDX_CTS] = lb_rts_i;
    lb_lvl[IDX_DSR] = lb_dtr_i;
    lb_lvl[IDX_RI]  = lb_out1_i;
    lb_lvl[IDX_DCD] = lb_out2_i;
  end

  msd_sync #(
    .WIDTH    (LINES),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_n),
    .q_o   (pin_sync_n)
  );

  assign lvl = loop_en_i ? lb_lvl : ~pin_sync_n;

  msd_delta #(
    .SETTLE(SETTLE)
  ) u_delta (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .clr_i  (status_rd_i),
    .delta_o(delta)
  );

  msd_flow u_flow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flow_en_i  (flow_en_i),
    .cts_act_i  (lvl[IDX_CTS]),
    .char_done_i(char_done_i),
    .tx_allow_o (tx_allow_o)
  );

  assign status_o = {lvl, delta};
  assign irq_o    = |delta;
endmodule

// File: rtl/msd_checker.sv
module msd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       status_rd_i,
  input logic       flow_en_i,
  input logic       char_done_i,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic       tx_allow_o
);
  a_r1_cts_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> ($past(status_o[4]) != $past(status_o[4], 2)));
  a_r1_dsr_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> ($past(status_o[5]) != $past(status_o[5], 2)));
  a_r1_dcd_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> ($past(status_o[7]) != $past(status_o[7], 2)));
  a_r2_ring_trailing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[2]) |-> ($past(status_o[6], 2) && !$past(status_o[6])));
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_rd_i |=> ((status_o[3:0] & $past(status_o[3:0])) == $past(status_o[3:0])));
  a_r5_irq_any: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (status_o[3:0] != 4'b0));
  a_r8_halt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_allow_o) |-> ($past(char_done_i) && $past(flow_en_i) && !$past(status_o[4])));
  a_r9_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_allow_o && (status_o[4] || !flow_en_i)) |=> tx_allow_o);
endmodule

bind modem_status_monitor msd_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_rd_i(status_rd_i),
  .flow_en_i  (flow_en_i),
  .char_done_i(char_done_i),
  .status_o   (status_o),
  .irq_o      (irq_o),
  .tx_allow_o (tx_allow_o)
);

// File: tb/modem_status_monitor_tb.sv
`timescale 1ns/1ps
module modem_status_monitor_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cts_n = 1'b0, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b0;
  logic rd = 1'b0, loop_en = 1'b0, lb_rts = 1'b0, lb_dtr = 1'b0, lb_out1 = 1'b0, lb_out2 = 1'b0;
  logic flow_en = 1'b0, char_done = 1'b0;
  logic [7:0] status;
  logic irq, tx_allow;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  modem_status_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cts_n_i(cts_n), .dsr_n_i(dsr_n), .ri_n_i(ri_n), .dcd_n_i(dcd_n),
    .status_rd_i(rd), .loop_en_i(loop_en), .lb_rts_i(lb_rts), .lb_dtr_i(lb_dtr),
    .lb_out1_i(lb_out1), .lb_out2_i(lb_out2), .flow_en_i(flow_en), .char_done_i(char_done),
    .status_o(status), .irq_o(irq), .tx_allow_o(tx_allow)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_read();
    rd = 1'b1; step(1); rd = 1'b0;
  endtask

  task automatic t_reset();
    step(6);
    chk("R10 flags after reset", status, 8'b1001_0000);
    chk("R10 irq after reset", {7'b0, irq}, 8'd0);
    chk("R9 tx_allow after reset", {7'b0, tx_allow}, 8'd1);
  endtask

  task automatic t_edges();
    dsr_n = 1'b0; step(2);
    chk("R6 dsr level after two edges", status, 8'b1011_0000);
    step(1);
    chk("R1 dsr flag", status, 8'b1011_0010);
    chk("R5 irq set", {7'b0, irq}, 8'd1);
    step(4);
    chk("R3 flag sticky", status[3:0], 8'b0010);
    do_read();
    chk("R3 read clears", status[3:0], 8'd0);
    chk("R5 irq clear", {7'b0, irq}, 8'd0);
    cts_n = 1'b1; step(3);
    chk("R1 cts deassert flag", status, 8'b1010_0001);
    dcd_n = 1'b1; step(3);
    chk("R1 dcd flag", status, 8'b0010_1001);
    do_read();
    dcd_n = 1'b0; step(3); do_read();
  endtask

  task automatic t_ring();
    ri_n = 1'b0; step(3);
    chk("R2 ring pin fall no flag", status, 8'b1110_0000);
    ri_n = 1'b1; step(2);
    chk("R2 ring level", status[7:4], 8'b1010);
    chk("R2 ring flag not yet", status[3:0], 8'd0);
    step(1);
    chk("R2 ring pin rise flag", status[3:0], 8'b0100);
    do_read();
  endtask

  task automatic t_collide();
    dsr_n = 1'b1; step(3);
    chk("R1 dsr flag before collide", status[3:0], 8'b0010);
    cts_n = 1'b0; step(2);
    do_read();
    chk("R4 edge wins over read", status[3:0], 8'b0001);
    do_read();
    chk("R3 second read clears", status[3:0], 8'd0);
  endtask

  task automatic t_loop();
    // pins now: cts asserted, others deasserted except dcd
    lb_rts = 1'b1; lb_dtr = 1'b0; lb_out1 = 1'b1; lb_out2 = 1'b1; loop_en = 1'b1;
    step(1);
    chk("R7 loopback levels", status[7:4], 8'b1101);
    do_read();
    chk("R7 flags cleared in loopback", status[3:0], 8'd0);
    lb_rts = 1'b0; step(1);
    chk("R7 rts loop flag", status, 8'b1100_0001);
    lb_out1 = 1'b0; step(1);
    chk("R7 out1 trailing sets ring flag", status[3:0], 8'b0101);
    do_read();
    lb_out1 = 1'b1; step(1);
    chk("R7 out1 rise no ring flag", status[3:0], 8'd0);
    loop_en = 1'b0; step(2); do_read();
    chk("R6 levels back to pins", status, 8'b1001_0000);
  endtask

  task automatic t_flow();
    flow_en = 1'b1;
    char_done = 1'b1; step(1); char_done = 1'b0;
    chk("R8 no halt while cts asserted", {7'b0, tx_allow}, 8'd1);
    cts_n = 1'b1; step(3);
    chk("R8 no halt before char end", {7'b0, tx_allow}, 8'd1);
    char_done = 1'b1; step(1); char_done = 1'b0;
    chk("R8 halt after char end", {7'b0, tx_allow}, 8'd0);
    cts_n = 1'b0; step(2);
    chk("R9 still halted at level", {7'b0, tx_allow}, 8'd0);
    step(1);
    chk("R9 resume on cts", {7'b0, tx_allow}, 8'd1);
    cts_n = 1'b1; step(3);
    char_done = 1'b1; step(1); char_done = 1'b0;
    chk("R8 halt again", {7'b0, tx_allow}, 8'd0);
    flow_en = 1'b0; step(1);
    chk("R9 resume on flow disable", {7'b0, tx_allow}, 8'd1);
    char_done = 1'b1; step(1); char_done = 1'b0; step(1);
    chk("R11 char_done ignored without flow", {7'b0, tx_allow}, 8'd1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    t_reset();
    t_edges();
    t_ring();
    t_collide();
    t_loop();
    t_flow();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule